// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one functional clock. Each channel owns a control word (run bit and a 14-bit clock divider), a 16-bit high-time count and a 16-bit period count. The channel divides the clock by (divider + 1) to form a tick. Its output is a waveform that is high for the first DC ticks of every PV-tick period. A single chip-wide run bit gates every channel. A channel produces pulses only when its own run bit and the chip-wide run bit are both set.

Software reaches the block through a plain 32-bit register port: select, write strobe, byte address, write data and a combinational read-data return. The channels are banked at a 16-byte stride. The chip-wide run bit has an address of its own, in the unused slot of the last bank. New high-time, period and divider values are held in shadow copies inside each channel. They are taken over only at the end of the current period, so a reconfiguration never yields a truncated or stretched pulse.

Top module: `quad_pwm`

## Requirements
- R1: Channel n (0 to 3) occupies byte addresses n*0x10 to n*0x10+0xF. The control word is at +0x0, with the run bit in bit 0 and the divider in bits 15:2. The high-time count (DC) is at +0x4, bits 15:0. The period count (PV) is at +0x8, bits 15:0. All other bits read as zero.
- R2: The chip-wide run bit is bit 0 of address 0x3C. A channel's output stays low unless that bit and the channel's own run bit are both set.
- R3: Control, high-time, period and chip-wide registers read back what was written, within their defined bits. Clearing only the run bit by read-modify-write leaves the divider value intact.
- R4: A channel starts running on the second rising edge after the write that enables it. It then repeats a period of (div+1)*PV clocks, and its output is high for the first (div+1)*DC clocks of each period.
- R5: If DC >= PV, the output stays high for the entire period. If DC = 0, it stays low. PV = 0 acts as PV = 1.
- R6: Once a channel is stopped, its output is low from the second rising edge after the stopping write, and its counters are cleared. A later restart begins a fresh period at count zero.
- R7: A DC, PV or divider written while a channel runs takes effect at the next period boundary. The remainder of the current period keeps the old values.
- R8: Reads of unmapped addresses return zero, and writes to them change no register.
- R9: After reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe (with reg_sel) |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, zero when not selected |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A stale shadow copy or a period counter that slips shows up at pwm_out as a pulse edge displaced from the position predicted from (div+1), DC and PV. It appears within one period of the change, since every sample is compared with a cycle-exact model. A decode error in the register file appears on the next read-back, either as a value written to the wrong bank or as an unmapped write that leaks into a live register. A counter that is not cleared on stop is exposed on restart, where the first period would come out shorter than the model predicts.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
   // offsets inside one channel bank
   localparam logic [3:0] OFS_CTRL   = 4'h0;
   localparam logic [3:0] OFS_HIGH   = 4'h4;
   localparam logic [3:0] OFS_PERIOD = 4'h8;
   // chip-wide run register address
   localparam int unsigned GLOBAL_ADDR = 'h3C;
   // control word layout
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_DIV_LSB = 2;
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs #(
   parameter int NCH    = 4,
   parameter int DIV_W  = 14,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel,
   input  logic                        wr,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic                        glob_run,
   output logic [NCH-1:0]              ch_run,
   output logic [NCH-1:0][DIV_W-1:0]   ch_div,
   output logic [NCH-1:0][CNT_W-1:0]   ch_high,
   output logic [NCH-1:0][CNT_W-1:0]   ch_period
);
   import qpwm_pkg::*;

   localparam int BANK_W = ADDR_W - 4;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("qpwm_regs: NCH must be 1..4 so banks stay clear of the global register");
   end
   if (DIV_W + CTRL_DIV_LSB > DATA_W || CNT_W > DATA_W) begin : g_bad_width
      $error("qpwm_regs: field widths exceed the data bus");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("qpwm_regs: address too narrow for the map");
   end

   logic [BANK_W-1:0] bank;
   logic [3:0]        slot;
   logic              glob_hit;

   assign bank     = addr[ADDR_W-1:4];
   assign slot     = addr[3:0];
   assign glob_hit = (addr == ADDR_W'(GLOBAL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_run  <= 1'b0;
         ch_run    <= '0;
         ch_div    <= '0;
         ch_high   <= '0;
         ch_period <= '0;
      end else if (sel && wr) begin
         if (glob_hit) begin
            glob_run <= wdata[0];
         end else begin
            for (int c = 0; c < NCH; c++) begin
               if (bank == BANK_W'(c)) begin
                  case (slot)
                     OFS_CTRL: begin
                        ch_run[c] <= wdata[CTRL_RUN_BIT];
                        ch_div[c] <= wdata[CTRL_DIV_LSB +: DIV_W];
                     end
                     OFS_HIGH:   ch_high[c]   <= wdata[CNT_W-1:0];
                     OFS_PERIOD: ch_period[c] <= wdata[CNT_W-1:0];
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel) begin
         if (glob_hit) begin
            rdata[0] = glob_run;
         end else begin
            for (int c = 0; c < NCH; c++) begin
               if (bank == BANK_W'(c)) begin
                  case (slot)
                     OFS_CTRL: begin
                        rdata[CTRL_RUN_BIT]          = ch_run[c];
                        rdata[CTRL_DIV_LSB +: DIV_W] = ch_div[c];
                     end
                     OFS_HIGH:   rdata[CNT_W-1:0] = ch_high[c];
                     OFS_PERIOD: rdata[CNT_W-1:0] = ch_period[c];
                     default: ;
                  endcase
               end
            end
         end
      end
   end

   // R2
   glob_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && glob_hit) |=> (glob_run == $past(wdata[0])));

   // R8
   no_sel_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |-> (rdata == '0));

endmodule

// File: rtl/qpwm_prescaler.sv
module qpwm_prescaler #(
   parameter int DIV_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   if (DIV_W < 1) begin : g_bad_div
      $error("qpwm_prescaler: DIV_W must be positive");
   end

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (cnt == limit) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign tick = !clr && (cnt == limit);

   // R4
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt <= limit));

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
   parameter int DIV_W   = 14,
   parameter int CNT_W   = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glob_run,
   input  logic             run_bit,
   input  logic [DIV_W-1:0] div,
   input  logic [CNT_W-1:0] high,
   input  logic [CNT_W-1:0] period,
   output logic             pwm_o
);
   logic             run, active;
   logic [DIV_W-1:0] div_sh;
   logic [CNT_W-1:0] high_sh, period_sh, pos;
   logic [CNT_W:0]   pos_next;
   logic             tick, last, wave;

   assign run      = glob_run && run_bit;
   assign pos_next = {1'b0, pos} + 1'b1;
   assign last     = (pos_next >= {1'b0, period_sh});

   qpwm_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!(run && active)),
      .limit (div_sh),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         pos       <= '0;
         div_sh    <= '0;
         high_sh   <= '0;
         period_sh <= '0;
      end else if (!run) begin
         active <= 1'b0;
         pos    <= '0;
      end else if (!active) begin
         active    <= 1'b1;
         pos       <= '0;
         div_sh    <= div;
         high_sh   <= high;
         period_sh <= period;
      end else if (tick) begin
         if (last) begin
            pos       <= '0;
            div_sh    <= div;
            high_sh   <= high;
            period_sh <= period;
         end else begin
            pos <= pos_next[CNT_W-1:0];
         end
      end
   end

   assign wave = active && (pos < high_sh);

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_o <= 1'b0;
         else        pwm_o <= wave;
      end
   end else begin : g_ocomb
      assign pwm_o = wave;
   end

   // R6
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!active && pos == '0));

   // R4
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && period_sh != '0) |-> (pos < period_sh));

   // R5
   full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && high_sh >= period_sh && high_sh != '0) |-> wave);

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(tick && last))
         |-> ($stable(high_sh) && $stable(period_sh) && $stable(div_sh)));

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm #(
   parameter int NCH     = 4,
   parameter int DIV_W   = 14,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NCH-1:0]    pwm_out
);
   logic                      glob_run;
   logic [NCH-1:0]            ch_run;
   logic [NCH-1:0][DIV_W-1:0] ch_div;
   logic [NCH-1:0][CNT_W-1:0] ch_high;
   logic [NCH-1:0][CNT_W-1:0] ch_period;

   qpwm_regs #(
      .NCH(NCH), .DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (reg_sel),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .glob_run  (glob_run),
      .ch_run    (ch_run),
      .ch_div    (ch_div),
      .ch_high   (ch_high),
      .ch_period (ch_period)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      qpwm_channel #(.DIV_W(DIV_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .glob_run (glob_run),
         .run_bit  (ch_run[c]),
         .div      (ch_div[c]),
         .high     (ch_high[c]),
         .period   (ch_period[c]),
         .pwm_o    (pwm_out[c])
      );
   end

   // R2
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_run && !$past(glob_run)) |-> (pwm_out == '0));

endmodule

// File: tb/sim_quad_pwm.sv
`timescale 1ns/1ps
module sim_quad_pwm;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  pwm_out;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   quad_pwm u0 (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pwm_out(pwm_out)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit model_out(int k, int dv, int pv, int dc);
      int p = (pv == 0) ? 1 : pv;
      return ((k / (dv + 1)) % p) < dc;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      reg_sel = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   int dv[4], pv[4], dc[4];
   logic [31:0] v;

   task automatic cfg(input int c, input int d, input int p, input int h, input bit en);
      wr(8'(c*16),     32'(d << 2) | 32'(en));
      wr(8'(c*16 + 4), 32'(h));
      wr(8'(c*16 + 8), 32'(p));
      dv[c] = d; pv[c] = p; dc[c] = h;
   endtask

   // after the global enable write returns, sample k = 0.. at successive negedges
   task automatic run_and_check(input int cycles, input string req);
      wr(8'h3C, 32'h1);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         for (int c = 0; c < 4; c++)
            check(pwm_out[c] == model_out(k, dv[c], pv[c], dc[c]), req,
                  32'(pwm_out[c]), 32'(model_out(k, dv[c], pv[c], dc[c])));
      end
      wr(8'h3C, 32'h0);
      @(negedge clk);
      check(pwm_out == 4'h0, "R2 outputs low after global stop", 32'(pwm_out), 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      check(pwm_out == 4'h0, "R9 outputs low", 32'(pwm_out), 0);
      for (int c = 0; c < 4; c++)
         for (int s = 0; s < 3; s++) begin
            rd(8'(c*16 + s*4), v);
            check(v == 0, "R9 register zero", v, 0);
         end
      rd(8'h3C, v); check(v == 0, "R9 global zero", v, 0);

      // R1 / R3 field layout and read-back
      wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, v);
      check(v == 32'h0000_FFFD, "R1 control layout", v, 32'h0000_FFFD);
      wr(8'h24, 32'hABCD_1234); rd(8'h24, v);
      check(v == 32'h0000_1234, "R1 high-time width", v, 32'h1234);
      wr(8'h28, 32'h5678_9ABC); rd(8'h28, v);
      check(v == 32'h0000_9ABC, "R3 period read-back", v, 32'h9ABC);
      wr(8'h3C, 32'hFFFF_FFFE); rd(8'h3C, v);
      check(v == 0, "R2 global bit0 only", v, 0);
      repeat (5) @(negedge clk);
      check(pwm_out == 0, "R2 channel enabled but global off", 32'(pwm_out), 0);

      // R8 unmapped addresses
      foreach (v[i]) ; // no-op
      for (int i = 0; i < 6; i++) begin
         logic [7:0] ua;
         ua = (i == 0) ? 8'h0C : (i == 1) ? 8'h1C : (i == 2) ? 8'h2C :
              (i == 3) ? 8'h40 : (i == 4) ? 8'h84 : 8'hFC;
         wr(ua, 32'hFFFF_FFFF); rd(ua, v);
         check(v == 0, "R8 unmapped read zero", v, 0);
      end
      rd(8'h24, v); check(v == 32'h1234, "R8 neighbour untouched", v, 32'h1234);
      rd(8'h3C, v); check(v == 0, "R8 global untouched", v, 0);
      rd(8'h00, v); check(v == 0, "R8 bank0 untouched", v, 0);
      wr(8'h20, 32'h0);

      // R5 directed corners
      cfg(0, 1, 5, 5, 1);
      cfg(1, 0, 5, 9, 1);
      cfg(2, 0, 4, 0, 1);
      cfg(3, 2, 0, 1, 1);
      run_and_check(40, "R5 corner waveform");

      // R4 random configurations
      for (int r = 0; r < 6; r++) begin
         for (int c = 0; c < 4; c++)
            cfg(c, int'($urandom % 4), 1 + int'($urandom % 12), int'($urandom % 15), 1);
         repeat (3) @(negedge clk);
         check(pwm_out == 0, "R2 configured, global off", 32'(pwm_out), 0);
         run_and_check(150, "R4 random waveform");
      end

      // R7 mid-period update
      for (int c = 1; c < 4; c++) cfg(c, 0, 1, 0, 0);
      cfg(0, 0, 10, 3, 1);
      wr(8'h3C, 32'h1);
      for (int k = 0; k < 30; k++) begin
         bit e;
         @(negedge clk);
         e = (k < 10) ? (k < 3) : (((k - 10) % 10) < 7);
         check(pwm_out[0] == e, "R7 update at boundary", 32'(pwm_out[0]), 32'(e));
         if (k == 4) begin
            reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'd7;
         end
         if (k == 5) begin
            reg_sel = 1'b0; reg_wr = 1'b0;
         end
      end

      // R3 / R6 read-modify-write stop and fresh restart
      cfg(0, 2, 4, 1, 1);
      repeat (7) @(negedge clk);
      rd(8'h00, v);
      check(v == 32'h9, "R3 control read-back", v, 32'h9);
      wr(8'h00, v & ~32'h1);
      @(negedge clk);
      check(pwm_out[0] == 1'b0, "R6 output low after stop", 32'(pwm_out[0]), 0);
      rd(8'h00, v);
      check(v == 32'h8, "R3 divider kept by RMW", v, 32'h8);
      repeat (5) @(negedge clk);
      wr(8'h00, v | 32'h1);
      for (int k = 0; k < 36; k++) begin
         @(negedge clk);
         check(pwm_out[0] == model_out(k, 2, 4, 1), "R6 restart from zero",
               32'(pwm_out[0]), 32'(model_out(k, 2, 4, 1)));
      end

      finish_run();
   end
endmodule